// File: doc/BRIEF.md
# Four-Way Page Translation Lookaside Buffer

This block turns a 32-bit virtual address into a physical address for a memory system built on 8 KB pages. It holds a table of 16 sets with four ways each. The low four bits of the virtual page number pick a set, and all four ways of that set are compared in parallel. When a way matches, its stored frame number replaces the upper address bits, unless a protection check rejects the access.

When a check fails, the block reports an exception vector code, in priority order:
- the entry is marked invalid;
- the entry belongs to another process;
- the entry refuses a write.

A lookup that matches no way reports a miss. Every fault loads a cause register with the page, the access type and the current process identifier. A miss or an invalid entry also loads a refill-select register with the set index, so that the fault handler knows where to put the new entry. Entries are written through a dedicated port: one set, one way and the fields of that entry per cycle.

A lookup is issued with a one-cycle request pulse. The result appears on the registered outputs on the following cycle.

Top module: `tlbx_lookup`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault`, `rsp_vec`, `rsp_paddr`, `rsp_flags`, `cause_q` and `refill_sel` are all zero.
- R2: A request sampled at a clock edge drives `rsp_valid` high after that edge. A lookup that passes every check gives `rsp_fault`=0, `rsp_vec`=0 and `rsp_paddr` = {stored frame number, vaddr[12:0]}. It also returns the stored flags on `rsp_flags`, laid out as on `tw_flags`: bit 4 global, bit 3 valid, bit 2 kernel, bit 1 write, bit 0 execute.
- R3: The set is chosen by vaddr[16:13]. A way hits when its stored page number equals vaddr[31:13]. When several ways of the set hit, the lowest-numbered way supplies the result.
- R4: A lookup with no hitting way faults with vector 0x8. It loads `refill_sel` with the set index in bits 3:0 and zero in the way field, bits 5:4. `refill_sel` changes only on a miss or an invalid-entry fault.
- R5: With `chk_valid_en` set, a hit on an entry whose valid flag is clear faults with vector 0x9 and loads `refill_sel` as a miss does. With `chk_valid_en` clear, the valid flag causes no fault.
- R6: A hit on an entry whose global flag is clear and whose stored PID is neither 0xFF nor equal to `cur_pid` faults with vector 0xA. This fault leaves `refill_sel` unchanged.
- R7: A write (`req_write`=1) that hits an entry whose write flag is clear faults with vector 0xB when `chk_write_en` is set. A read, or a write with `chk_write_en` clear, is not rejected by the write flag.
- R8: When several checks fail on one lookup, only the highest-priority code is reported: invalid (0x9), then PID (0xA), then write (0xB). Every fault sets `rsp_fault` and drives `rsp_paddr` to zero.
- R9: On every fault, `cause_q` is loaded as follows:

  | Bits | Content |
  |------|---------|
  | 31:13 | vaddr[31:13] |
  | 12:10 | zero |
  | 9:8 | access code: 01 for a read, 10 for a write |
  | 7:0 | `cur_pid` |

  A lookup without a fault leaves `cause_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request, one cycle per lookup |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| cur_pid | input | 8 | Identifier of the running process |
| chk_valid_en | input | 1 | Enables the valid-flag check |
| chk_write_en | input | 1 | Enables the write-permission check |
| tw_en | input | 1 | Writes one table entry at the clock edge |
| tw_set | input | 4 | Set of the entry being written |
| tw_way | input | 2 | Way of the entry being written |
| tw_vpn | input | 19 | Virtual page number to store |
| tw_pid | input | 8 | Process identifier to store (0xFF matches any) |
| tw_pfn | input | 19 | Physical frame number to store |
| tw_flags | input | 5 | Flags to store: global, valid, kernel, write, execute in bits 4..0 |
| rsp_valid | output | 1 | Result of the previous cycle's request is present |
| rsp_fault | output | 1 | The lookup faulted |
| rsp_vec | output | 4 | Vector code: 0 none, 0x8 miss, 0x9 invalid, 0xA PID, 0xB write |
| rsp_paddr | output | 32 | Translated physical address, zero on a fault |
| rsp_flags | output | 5 | Flags of the hitting entry, zero on a miss |
| cause_q | output | 32 | Cause of the latest fault |
| refill_sel | output | 6 | Refill target: set in bits 3:0, way in bits 5:4 |

## Verification
Translation is tried with distinct pages that land in different sets, so that a wrong index bit shows up as a miss. A set is also loaded with the same page in two ways holding different frames, so that the frame returned shows whether the lowest way wins. Flag patterns are swept with each check enabled and then disabled:
- a cleared valid flag;
- a foreign PID, together with the 0xFF and global escapes;
- a cleared write flag under a read and under a write.

Each of these separates a working check from one that is inverted or ignored. Entries that fail several checks at once separate the priority order. A fault followed by a clean hit shows that the cause register and the refill target are loaded only when they should be.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

   typedef enum logic [3:0] {
      VEC_NONE  = 4'h0,
      VEC_MISS  = 4'h8,
      VEC_INVAL = 4'h9,
      VEC_PID   = 4'hA,
      VEC_WPROT = 4'hB
   } tlbx_vec_e;

   localparam int FLAG_W = 5;
   localparam int FL_X   = 0;
   localparam int FL_W   = 1;
   localparam int FL_K   = 2;
   localparam int FL_V   = 3;
   localparam int FL_G   = 4;

   localparam logic [1:0] ACC_RD = 2'b01;
   localparam logic [1:0] ACC_WR = 2'b10;

endpackage

// File: rtl/tlbx_store.sv
module tlbx_store #(
   parameter int SET_W  = 4,
   parameter int WAY_W  = 2,
   parameter int VPN_W  = 19,
   parameter int PFN_W  = 19,
   parameter int PID_W  = 8,
   parameter int FLAG_W = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [SET_W-1:0]                 wr_set,
   input  logic [WAY_W-1:0]                 wr_way,
   input  logic [VPN_W-1:0]                 wr_vpn,
   input  logic [PID_W-1:0]                 wr_pid,
   input  logic [PFN_W-1:0]                 wr_pfn,
   input  logic [FLAG_W-1:0]                wr_flags,
   input  logic [SET_W-1:0]                 rd_set,
   output logic [(1<<WAY_W)-1:0][VPN_W-1:0] rd_vpn,
   output logic [(1<<WAY_W)-1:0][PID_W-1:0] rd_pid,
   output logic [(1<<WAY_W)-1:0][PFN_W-1:0] rd_pfn,
   output logic [(1<<WAY_W)-1:0][FLAG_W-1:0] rd_flags
);
   localparam int SETS = 1 << SET_W;
   localparam int WAYS = 1 << WAY_W;

   logic [SETS-1:0][WAYS-1:0][VPN_W-1:0]  vpn_q;
   logic [SETS-1:0][WAYS-1:0][PID_W-1:0]  pid_q;
   logic [SETS-1:0][WAYS-1:0][PFN_W-1:0]  pfn_q;
   logic [SETS-1:0][WAYS-1:0][FLAG_W-1:0] flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q   <= '0;
         pid_q   <= '0;
         pfn_q   <= '0;
         flags_q <= '0;
      end else if (wr_en) begin
         vpn_q[wr_set][wr_way]   <= wr_vpn;
         pid_q[wr_set][wr_way]   <= wr_pid;
         pfn_q[wr_set][wr_way]   <= wr_pfn;
         flags_q[wr_set][wr_way] <= wr_flags;
      end
   end

   assign rd_vpn   = vpn_q[rd_set];
   assign rd_pid   = pid_q[rd_set];
   assign rd_pfn   = pfn_q[rd_set];
   assign rd_flags = flags_q[rd_set];

endmodule

// File: rtl/tlbx_match.sv
module tlbx_match #(
   parameter int WAY_W = 2,
   parameter int VPN_W = 19
) (
   input  logic [(1<<WAY_W)-1:0][VPN_W-1:0] way_vpn,
   input  logic [VPN_W-1:0]                 vpn,
   output logic                             hit,
   output logic [WAY_W-1:0]                 hit_way
);
   localparam int WAYS = 1 << WAY_W;

   logic [WAYS-1:0] eq;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = (way_vpn[w] == vpn);
   end

   // lowest-numbered equal way wins: scan downward so the last write is the lowest
   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (eq[w]) hit_way = WAY_W'(w);
      end
   end

   assign hit = |eq;

endmodule

// File: rtl/tlbx_check.sv
module tlbx_check
   import tlbx_pkg::*;
#(
   parameter int PID_W = 8
) (
   input  logic              hit,
   input  logic [FLAG_W-1:0] flags,
   input  logic [PID_W-1:0]  ent_pid,
   input  logic [PID_W-1:0]  cur_pid,
   input  logic              is_write,
   input  logic              chk_valid,
   input  logic              chk_write,
   output tlbx_vec_e         vec,
   output logic              load_sel
);
   logic pid_ok;

   assign pid_ok = flags[FL_G] || (ent_pid == {PID_W{1'b1}}) || (ent_pid == cur_pid);

   always_comb begin
      if (!hit)
         vec = VEC_MISS;
      else if (chk_valid && !flags[FL_V])
         vec = VEC_INVAL;
      else if (!pid_ok)
         vec = VEC_PID;
      else if (is_write && chk_write && !flags[FL_W])
         vec = VEC_WPROT;
      else
         vec = VEC_NONE;
   end

   assign load_sel = (vec == VEC_MISS) || (vec == VEC_INVAL);

endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
   import tlbx_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PAGE_W = 13,
   parameter int SET_W  = 4,
   parameter int WAY_W  = 2,
   parameter int PID_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [VA_W-1:0]         req_vaddr,
   input  logic                    req_write,
   input  logic [PID_W-1:0]        cur_pid,
   input  logic                    chk_valid_en,
   input  logic                    chk_write_en,
   input  logic                    tw_en,
   input  logic [SET_W-1:0]        tw_set,
   input  logic [WAY_W-1:0]        tw_way,
   input  logic [VA_W-PAGE_W-1:0]  tw_vpn,
   input  logic [PID_W-1:0]        tw_pid,
   input  logic [VA_W-PAGE_W-1:0]  tw_pfn,
   input  logic [FLAG_W-1:0]       tw_flags,
   output logic                    rsp_valid,
   output logic                    rsp_fault,
   output logic [3:0]              rsp_vec,
   output logic [VA_W-1:0]         rsp_paddr,
   output logic [FLAG_W-1:0]       rsp_flags,
   output logic [VA_W-1:0]         cause_q,
   output logic [SET_W+WAY_W-1:0]  refill_sel
);
   localparam int VPN_W = VA_W - PAGE_W;
   localparam int PFN_W = VPN_W;
   localparam int WAYS  = 1 << WAY_W;
   localparam int PAD_W = PAGE_W - 2 - PID_W;

   if (VPN_W <= SET_W) begin : g_bad_index
      $error("tlbx_lookup: page number must be wider than the set index");
   end
   if (PAD_W < 1) begin : g_bad_cause
      $error("tlbx_lookup: page offset too narrow for the cause layout");
   end

   logic [VPN_W-1:0]                vpn;
   logic [SET_W-1:0]                set_idx;
   logic [WAYS-1:0][VPN_W-1:0]      way_vpn;
   logic [WAYS-1:0][PID_W-1:0]      way_pid;
   logic [WAYS-1:0][PFN_W-1:0]      way_pfn;
   logic [WAYS-1:0][FLAG_W-1:0]     way_flags;
   logic                            hit;
   logic [WAY_W-1:0]                hit_way;
   logic [FLAG_W-1:0]               sel_flags;
   logic [PID_W-1:0]                sel_pid;
   logic [PFN_W-1:0]                sel_pfn;
   tlbx_vec_e                       vec;
   logic                            load_sel;

   assign vpn     = req_vaddr[VA_W-1:PAGE_W];
   assign set_idx = vpn[SET_W-1:0];

   tlbx_store #(
      .SET_W (SET_W), .WAY_W (WAY_W), .VPN_W (VPN_W),
      .PFN_W (PFN_W), .PID_W (PID_W), .FLAG_W(FLAG_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tw_en),
      .wr_set  (tw_set),
      .wr_way  (tw_way),
      .wr_vpn  (tw_vpn),
      .wr_pid  (tw_pid),
      .wr_pfn  (tw_pfn),
      .wr_flags(tw_flags),
      .rd_set  (set_idx),
      .rd_vpn  (way_vpn),
      .rd_pid  (way_pid),
      .rd_pfn  (way_pfn),
      .rd_flags(way_flags)
   );

   tlbx_match #(.WAY_W(WAY_W), .VPN_W(VPN_W)) u_match (
      .way_vpn(way_vpn),
      .vpn    (vpn),
      .hit    (hit),
      .hit_way(hit_way)
   );

   assign sel_flags = hit ? way_flags[hit_way] : '0;
   assign sel_pid   = way_pid[hit_way];
   assign sel_pfn   = way_pfn[hit_way];

   tlbx_check #(.PID_W(PID_W)) u_check (
      .hit      (hit),
      .flags    (sel_flags),
      .ent_pid  (sel_pid),
      .cur_pid  (cur_pid),
      .is_write (req_write),
      .chk_valid(chk_valid_en),
      .chk_write(chk_write_en),
      .vec      (vec),
      .load_sel (load_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_vec    <= '0;
         rsp_paddr  <= '0;
         rsp_flags  <= '0;
         cause_q    <= '0;
         refill_sel <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault <= (vec != VEC_NONE);
            rsp_vec   <= vec;
            rsp_flags <= sel_flags;
            rsp_paddr <= (vec == VEC_NONE) ? {sel_pfn, req_vaddr[PAGE_W-1:0]} : '0;
            if (vec != VEC_NONE)
               cause_q <= {vpn, {PAD_W{1'b0}}, (req_write ? ACC_WR : ACC_RD), cur_pid};
            if (load_sel)
               refill_sel <= {{WAY_W{1'b0}}, set_idx};
         end
      end
   end

   // R2
   resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2
   clean_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_vec == 4'h0));

   // R8
   fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_vec[3:2] == 2'b10 && rsp_paddr == '0));

   // R4
   sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(refill_sel));

   // R6
   pid_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_vec == 4'hA || rsp_vec == 4'hB)) |-> $stable(refill_sel));

   // R9
   cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> $stable(cause_q));

endmodule

// File: tb/tlbx_lookup_test.sv
module tlbx_lookup_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic [7:0]  cur_pid = '0;
   logic        chk_valid_en = 1'b0;
   logic        chk_write_en = 1'b0;
   logic        tw_en = 1'b0;
   logic [3:0]  tw_set = '0;
   logic [1:0]  tw_way = '0;
   logic [18:0] tw_vpn = '0;
   logic [7:0]  tw_pid = '0;
   logic [18:0] tw_pfn = '0;
   logic [4:0]  tw_flags = '0;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [3:0]  rsp_vec;
   logic [31:0] rsp_paddr;
   logic [4:0]  rsp_flags;
   logic [31:0] cause_q;
   logic [5:0]  refill_sel;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   tlbx_lookup uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
      .cur_pid(cur_pid), .chk_valid_en(chk_valid_en), .chk_write_en(chk_write_en),
      .tw_en(tw_en), .tw_set(tw_set), .tw_way(tw_way), .tw_vpn(tw_vpn),
      .tw_pid(tw_pid), .tw_pfn(tw_pfn), .tw_flags(tw_flags),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_vec(rsp_vec),
      .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags), .cause_q(cause_q),
      .refill_sel(refill_sel)
   );

   // flag encoding: bit4 global, bit3 valid, bit2 kernel, bit1 write, bit0 execute
   localparam logic [4:0] F_G = 5'b10000;
   localparam logic [4:0] F_V = 5'b01000;
   localparam logic [4:0] F_K = 5'b00100;
   localparam logic [4:0] F_W = 5'b00010;
   localparam logic [4:0] F_X = 5'b00001;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic put_entry(input logic [31:0] va, input logic [1:0] way,
                            input logic [7:0] pid, input logic [18:0] pfn,
                            input logic [4:0] flags);
      @(negedge clk);
      tw_en = 1'b1; tw_set = va[16:13]; tw_way = way; tw_vpn = va[31:13];
      tw_pid = pid; tw_pfn = pfn; tw_flags = flags;
      @(negedge clk);
      tw_en = 1'b0;
   endtask

   task automatic lookup(input logic [31:0] va, input logic wr);
      @(negedge clk);
      req_vaddr = va; req_write = wr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [31:0] exp_cause(input logic [31:0] va, input logic wr,
                                             input logic [7:0] pid);
      return {va[31:13], 3'b000, (wr ? 2'b10 : 2'b01), pid};
   endfunction

   task automatic expect_ok(input string req, input logic [31:0] va,
                            input logic [18:0] pfn, input logic [4:0] flags);
      check(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
      check(req, "rsp_fault", {31'd0, rsp_fault}, 32'd0);
      check(req, "rsp_vec",   {28'd0, rsp_vec}, 32'd0);
      check(req, "rsp_paddr", rsp_paddr, {pfn, va[12:0]});
      check(req, "rsp_flags", {27'd0, rsp_flags}, {27'd0, flags});
   endtask

   task automatic expect_fault(input string req, input logic [3:0] vec,
                               input logic [31:0] va, input logic wr, input logic [7:0] pid);
      check(req, "rsp_fault", {31'd0, rsp_fault}, 32'd1);
      check(req, "rsp_vec",   {28'd0, rsp_vec}, {28'd0, vec});
      check(req, "rsp_paddr", rsp_paddr, 32'd0);
      check(req, "cause_q",   cause_q, exp_cause(va, wr, pid));
   endtask

   task automatic t_reset();
      check("R1", "rsp_valid",  {31'd0, rsp_valid}, 32'd0);
      check("R1", "rsp_fault",  {31'd0, rsp_fault}, 32'd0);
      check("R1", "rsp_vec",    {28'd0, rsp_vec}, 32'd0);
      check("R1", "rsp_paddr",  rsp_paddr, 32'd0);
      check("R1", "rsp_flags",  {27'd0, rsp_flags}, 32'd0);
      check("R1", "cause_q",    cause_q, 32'd0);
      check("R1", "refill_sel", {26'd0, refill_sel}, 32'd0);
   endtask

   task automatic t_hit();
      logic [31:0] va1 = 32'h1234_5678;
      logic [31:0] va2 = 32'hA00E_3FFF;
      chk_valid_en = 1'b1; chk_write_en = 1'b1; cur_pid = 8'h21;
      put_entry(va1, 2'd2, 8'h21, 19'h5_1234, F_V | F_W | F_X);
      put_entry(va2, 2'd0, 8'h00, 19'h0_0ABC, F_G | F_V | F_K);
      lookup(va1, 1'b1);
      expect_ok("R2", va1, 19'h5_1234, F_V | F_W | F_X);
      lookup(va2, 1'b0);
      expect_ok("R2", va2, 19'h0_0ABC, F_G | F_V | F_K);
      // a different page landing in va1's set must miss (R3 index vs full tag)
      lookup(va1 ^ 32'h0002_0000, 1'b0);
      check("R3", "tag compare", {28'd0, rsp_vec}, 32'h8);
   endtask

   task automatic t_lowest_way();
      logic [31:0] va = 32'h0BCD_C010;
      put_entry(va, 2'd3, 8'hFF, 19'h7_7777, F_V);
      put_entry(va, 2'd1, 8'hFF, 19'h1_1111, F_V);
      lookup(va, 1'b0);
      check("R3", "lowest way paddr", rsp_paddr, {19'h1_1111, va[12:0]});
   endtask

   task automatic t_miss();
      logic [31:0] va = 32'h7654_A123;
      cur_pid = 8'h3C;
      lookup(va, 1'b1);
      expect_fault("R4", 4'h8, va, 1'b1, 8'h3C);
      check("R4", "refill_sel", {26'd0, refill_sel}, {28'd0, va[16:13]});
      lookup(32'h0000_6000 | 32'h0010_0000, 1'b0);
      check("R4", "refill_sel 2", {26'd0, refill_sel}, 32'h3);
      check("R9", "cause read", cause_q, exp_cause(32'h0010_6000, 1'b0, 8'h3C));
   endtask

   task automatic t_invalid();
      logic [31:0] va = 32'h4444_8800;
      cur_pid = 8'h10;
      put_entry(va, 2'd0, 8'h10, 19'h2_2222, F_W);
      chk_valid_en = 1'b1;
      lookup(va, 1'b0);
      expect_fault("R5", 4'h9, va, 1'b0, 8'h10);
      check("R5", "refill_sel", {26'd0, refill_sel}, {28'd0, va[16:13]});
      chk_valid_en = 1'b0;
      lookup(va, 1'b0);
      expect_ok("R5", va, 19'h2_2222, F_W);
      chk_valid_en = 1'b1;
   endtask

   task automatic t_pid();
      logic [31:0] va  = 32'h2000_2000;
      logic [31:0] vg  = 32'h2000_4000;
      logic [31:0] vf  = 32'h2000_8000;
      logic [5:0]  sel_before;
      put_entry(va, 2'd1, 8'h33, 19'h3_0001, F_V | F_W);
      put_entry(vg, 2'd1, 8'h33, 19'h3_0002, F_G | F_V | F_W);
      put_entry(vf, 2'd1, 8'hFF, 19'h3_0003, F_V | F_W);
      sel_before = refill_sel;
      cur_pid = 8'h44;
      lookup(va, 1'b1);
      expect_fault("R6", 4'hA, va, 1'b1, 8'h44);
      check("R6", "refill_sel kept", {26'd0, refill_sel}, {26'd0, sel_before});
      lookup(vg, 1'b0);
      expect_ok("R6", vg, 19'h3_0002, F_G | F_V | F_W);
      lookup(vf, 1'b0);
      expect_ok("R6", vf, 19'h3_0003, F_V | F_W);
      cur_pid = 8'h33;
      lookup(va, 1'b0);
      expect_ok("R6", va, 19'h3_0001, F_V | F_W);
   endtask

   task automatic t_wprot();
      logic [31:0] va = 32'h5555_E000;
      logic [31:0] cause_before;
      cur_pid = 8'h07;
      put_entry(va, 2'd2, 8'h07, 19'h4_4444, F_V);
      chk_write_en = 1'b1;
      lookup(va, 1'b1);
      expect_fault("R7", 4'hB, va, 1'b1, 8'h07);
      cause_before = cause_q;
      lookup(va, 1'b0);
      expect_ok("R7", va, 19'h4_4444, F_V);
      check("R9", "cause held", cause_q, cause_before);
      chk_write_en = 1'b0;
      lookup(va, 1'b1);
      expect_ok("R7", va, 19'h4_4444, F_V);
      chk_write_en = 1'b1;
   endtask

   task automatic t_priority();
      logic [31:0] va = 32'h6666_0000;
      chk_valid_en = 1'b1; chk_write_en = 1'b1; cur_pid = 8'h01;
      put_entry(va, 2'd0, 8'h02, 19'h6_0000, 5'b00000);
      lookup(va, 1'b1);
      expect_fault("R8", 4'h9, va, 1'b1, 8'h01);
      put_entry(va, 2'd0, 8'h02, 19'h6_0000, F_V);
      lookup(va, 1'b1);
      expect_fault("R8", 4'hA, va, 1'b1, 8'h01);
      chk_valid_en = 1'b0;
      put_entry(va, 2'd0, 8'h02, 19'h6_0000, F_G);
      lookup(va, 1'b1);
      expect_fault("R8", 4'hB, va, 1'b1, 8'h01);
      chk_valid_en = 1'b1;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_hit();
      t_lowest_way();
      t_miss();
      t_invalid();
      t_pid();
      t_wprot();
      t_priority();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule